// File: doc/BRIEF.md
# RTS Lead and Lag Sequencer

This block frames every transmission on a half-duplex line with the request-to-send signal. In automatic mode it raises RTS when data is waiting. It holds back the transmitter's start permission for a programmed lead interval. It then lets the transmitter run. Once nothing is pending and the transmitter is idle, it keeps RTS raised for a programmed lag interval. Both intervals are counted either in system clock cycles or in bit-period ticks supplied by the baud generator.

In manual mode a configuration bit sets the RTS level directly, and the sequencer stays parked. The block also applies selectable polarity to RTS and to the incoming CTS line. It can hold off transmit starts while CTS is inactive, and it passes through the output enables for the TX and RTS pad drivers. The transmitter, the baud generator and the registers that hold the configuration all sit outside this block.

Top module: `rts_lead_lag_ctrl`

## Requirements
- R1: With `cfg_auto`=0, the logical RTS level equals `cfg_manual_rts`, and the sequencer is idle one cycle later.
- R2: With `cfg_auto`=1 and `tx_pending` seen while idle with a nonzero lead, RTS becomes active after the next clock edge. `tx_start_ok` then stays low for exactly `cfg_lead` units and rises after the edge that consumes the last unit.
- R3: With `cfg_count_clk`=1, a unit is one clock cycle. With `cfg_count_clk`=0, a unit is one clock cycle in which `bit_tick` is high.
- R4: A lead of 0 lets `tx_start_ok` rise after the first edge that sees `tx_pending`.
- R5: After the edge at which `tx_pending` and `tx_busy` are both low during sending, RTS stays active for exactly `cfg_lag` units and then goes inactive. `tx_start_ok` is low throughout this lag interval.
- R6: If `tx_pending` rises during the lag interval, sending resumes at the next edge without a new lead interval, and RTS never drops.
- R7: `rts_pin` is high when RTS is active if `cfg_rts_act_high`=1, and low when RTS is active if it is 0. CTS counts as active when `cts_pin` equals `cfg_cts_act_high`.
- R8: With `cfg_cts_gate`=1, `tx_start_ok` is low whenever CTS is inactive. With `cfg_cts_gate`=0, CTS has no effect on `tx_start_ok`.
- R9: `tx_oe` follows `cfg_drv_tx_en`, and `rts_oe` follows `cfg_drv_rts_en`.
- R10: In automatic mode, `tx_start_ok` is high only while sending. In manual mode it equals the CTS condition of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto | input | 1 | 1: hardware sequencing of RTS, 0: manual level |
| cfg_manual_rts | input | 1 | Logical RTS level in manual mode |
| cfg_count_clk | input | 1 | Interval unit: 1 clock cycles, 0 bit ticks |
| cfg_lead | input | CNT_W | Lead interval length in units |
| cfg_lag | input | CNT_W | Lag interval length in units |
| cfg_rts_act_high | input | 1 | RTS pin polarity, 1 = active high |
| cfg_cts_act_high | input | 1 | CTS pin polarity, 1 = active high |
| cfg_cts_gate | input | 1 | Hold off transmit start while CTS is inactive |
| cfg_drv_tx_en | input | 1 | Enable for the TX pad driver |
| cfg_drv_rts_en | input | 1 | Enable for the RTS pad driver |
| tx_pending | input | 1 | Transmit data is waiting |
| tx_busy | input | 1 | Transmitter is shifting a character |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| cts_pin | input | 1 | Raw CTS line |
| rts_pin | output | 1 | RTS line after polarity |
| tx_start_ok | output | 1 | Transmitter may start a character |
| tx_oe | output | 1 | TX pad output enable |
| rts_oe | output | 1 | RTS pad output enable |

## Verification
A sequencer stuck in the wrong phase shows up at the ports within one unit. A missed lead or lag shows as `tx_start_ok` rising too early, or as RTS dropping while the transmitter could still be on the wire. An off-by-one in the span counter shows as an interval one unit long or short. Each interval is therefore measured edge by edge, in both unit modes and with random lengths. A lag that wrongly restarts the lead would stretch the resume path from one cycle to many, so the resume latency is timed directly.

// File: rtl/rts_ll_pkg.sv
package rts_ll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_SEND = 2'd2,
        ST_LAG  = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/rts_ll_timer.sv
module rts_ll_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             unit,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [EXT_W-1:0] cnt_next;

    always_comb begin
        cnt_next = {1'b0, cnt_q} + EXT_W'(1);
        done     = unit && (cnt_next == {1'b0, limit});
        cnt_d    = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (unit) begin
            cnt_d = cnt_next[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rts_ll_seq.sv
module rts_ll_seq
    import rts_ll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_en,
    input  logic       pending,
    input  logic       busy,
    input  logic       lead_zero,
    input  logic       lag_zero,
    input  logic       span_done,
    output seq_state_e state,
    output logic       timer_clear
);
    seq_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (!auto_en) begin
            regs_d.state = ST_IDLE;
        end else begin
            unique case (regs_q.state)
                ST_IDLE: if (pending) regs_d.state = lead_zero ? ST_SEND : ST_LEAD;
                ST_LEAD: if (span_done || lead_zero) regs_d.state = ST_SEND;
                ST_SEND: if (!pending && !busy) regs_d.state = lag_zero ? ST_IDLE : ST_LAG;
                ST_LAG: begin
                    if (pending) begin
                        regs_d.state = ST_SEND;
                    end else if (span_done || lag_zero) begin
                        regs_d.state = ST_IDLE;
                    end
                end
                default: regs_d.state = ST_IDLE;
            endcase
        end
        timer_clear = (regs_d.state != regs_q.state)
                   || !(regs_q.state == ST_LEAD || regs_q.state == ST_LAG);
        state = regs_q.state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/rts_ll_pins.sv
module rts_ll_pins (
    input  logic auto_en,
    input  logic manual_lvl,
    input  logic rts_req,
    input  logic in_send,
    input  logic rts_act_high,
    input  logic cts_act_high,
    input  logic cts_gate,
    input  logic cts_raw,
    input  logic drv_tx_en,
    input  logic drv_rts_en,
    output logic rts_out,
    output logic start_ok,
    output logic tx_oe,
    output logic rts_oe
);
    logic rts_level;
    logic cts_active;
    logic cts_ok;

    always_comb begin
        rts_level  = auto_en ? rts_req : manual_lvl;
        rts_out    = rts_act_high ? rts_level : ~rts_level;
        cts_active = cts_act_high ? cts_raw : ~cts_raw;
        cts_ok     = ~cts_gate | cts_active;
        start_ok   = cts_ok & (auto_en ? in_send : 1'b1);
        tx_oe      = drv_tx_en;
        rts_oe     = drv_rts_en;
    end
endmodule

// File: rtl/rts_lead_lag_ctrl.sv
module rts_lead_lag_ctrl
    import rts_ll_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_auto,
    input  logic             cfg_manual_rts,
    input  logic             cfg_count_clk,
    input  logic [CNT_W-1:0] cfg_lead,
    input  logic [CNT_W-1:0] cfg_lag,
    input  logic             cfg_rts_act_high,
    input  logic             cfg_cts_act_high,
    input  logic             cfg_cts_gate,
    input  logic             cfg_drv_tx_en,
    input  logic             cfg_drv_rts_en,
    input  logic             tx_pending,
    input  logic             tx_busy,
    input  logic             bit_tick,
    input  logic             cts_pin,
    output logic             rts_pin,
    output logic             tx_start_ok,
    output logic             tx_oe,
    output logic             rts_oe
);
    seq_state_e       seq_state;
    logic             timer_clear;
    logic             span_done;
    logic             unit_pulse;
    logic [CNT_W-1:0] span_limit;

    // one span counter serves both the lead and the lag phase
    always_comb begin
        unit_pulse = cfg_count_clk | bit_tick;
        span_limit = (seq_state == ST_LAG) ? cfg_lag : cfg_lead;
    end

    rts_ll_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .unit  (unit_pulse),
        .limit (span_limit),
        .done  (span_done)
    );

    rts_ll_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_en     (cfg_auto),
        .pending     (tx_pending),
        .busy        (tx_busy),
        .lead_zero   (cfg_lead == '0),
        .lag_zero    (cfg_lag == '0),
        .span_done   (span_done),
        .state       (seq_state),
        .timer_clear (timer_clear)
    );

    rts_ll_pins u_pins (
        .auto_en      (cfg_auto),
        .manual_lvl   (cfg_manual_rts),
        .rts_req      (seq_state != ST_IDLE),
        .in_send      (seq_state == ST_SEND),
        .rts_act_high (cfg_rts_act_high),
        .cts_act_high (cfg_cts_act_high),
        .cts_gate     (cfg_cts_gate),
        .cts_raw      (cts_pin),
        .drv_tx_en    (cfg_drv_tx_en),
        .drv_rts_en   (cfg_drv_rts_en),
        .rts_out      (rts_pin),
        .start_ok     (tx_start_ok),
        .tx_oe        (tx_oe),
        .rts_oe       (rts_oe)
    );
endmodule

// File: rtl/rts_ll_chk.sv
module rts_ll_chk
    import rts_ll_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_auto,
    input logic [CNT_W-1:0] cfg_lead,
    input logic             cfg_cts_gate,
    input logic             cfg_cts_act_high,
    input logic             cts_pin,
    input logic             tx_pending,
    input logic             tx_start_ok,
    input seq_state_e       seq_state
);
    AST_MANUAL_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_auto |=> seq_state == ST_IDLE); // R1

    AST_LEAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_auto && seq_state == ST_IDLE && tx_pending && cfg_lead != '0
        |=> seq_state == ST_LEAD); // R2

    AST_DIRECT_SEND_ZERO_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == ST_SEND && $past(seq_state) == ST_IDLE
        |-> $past(cfg_lead) == '0); // R4

    AST_LAG_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_auto && seq_state == ST_LAG && tx_pending |=> seq_state == ST_SEND); // R6

    AST_CTS_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cts_gate && (cts_pin != cfg_cts_act_high) |-> !tx_start_ok); // R8

    AST_PERMIT_IN_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_auto && tx_start_ok |-> seq_state == ST_SEND); // R10
endmodule

bind rts_lead_lag_ctrl rts_ll_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_auto         (cfg_auto),
    .cfg_lead         (cfg_lead),
    .cfg_cts_gate     (cfg_cts_gate),
    .cfg_cts_act_high (cfg_cts_act_high),
    .cts_pin          (cts_pin),
    .tx_pending       (tx_pending),
    .tx_start_ok      (tx_start_ok),
    .seq_state        (seq_state)
);

// File: tb/sim_rts_lead_lag_ctrl.sv
module sim_rts_lead_lag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_auto = 1'b1, cfg_manual_rts = 1'b0, cfg_count_clk = 1'b1;
    logic [7:0] cfg_lead = 8'd0, cfg_lag = 8'd0;
    logic       cfg_rts_act_high = 1'b1, cfg_cts_act_high = 1'b1, cfg_cts_gate = 1'b0;
    logic       cfg_drv_tx_en = 1'b0, cfg_drv_rts_en = 1'b0;
    logic       tx_pending = 1'b0, tx_busy = 1'b0, bit_tick = 1'b0, cts_pin = 1'b1;
    logic       rts_pin, tx_start_ok, tx_oe, rts_oe;

    int checks = 0;
    int fails = 0;
    int tick_per = 3;
    bit done_flag = 0;

    always #4 clk = ~clk;

    rts_lead_lag_ctrl u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pin_level(input logic active, input logic act_high);
        return active ? act_high : ~act_high;
    endfunction

    // bit-tick source, updated on falling edges
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            bit_tick = (tick_per != 0) && (cnt % tick_per == 0);
        end
    end

    // one automatic frame: measure lead, hold in send, measure lag
    task automatic run_frame(input int lead, input int lag, input bit by_clk,
                             input bit rts_hi, input string tag);
        int  units;
        bit  ok;
        @(negedge clk);
        cfg_auto = 1; cfg_cts_gate = 0; cfg_count_clk = by_clk;
        cfg_lead = 8'(lead); cfg_lag = 8'(lag); cfg_rts_act_high = rts_hi;
        @(negedge clk); #1;
        chk(rts_pin == pin_level(1'b0, rts_hi), {"R7 idle level ", tag}, rts_pin, pin_level(1'b0, rts_hi));
        tx_pending = 1;
        units = 0; ok = 1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #1;
            if (tx_start_ok) break;
            if (rts_pin != rts_hi) ok = 0;
            if (by_clk || bit_tick) units++;
        end
        chk(units == lead, {"R2/R3 lead units ", tag}, units, lead);
        chk(ok, {"R2 rts active in lead ", tag}, ok, 1);
        tx_busy = 1; tx_pending = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(tx_start_ok && rts_pin == rts_hi, {"R10 send holds while busy ", tag}, tx_start_ok, 1);
        @(negedge clk);
        tx_busy = 0;
        units = 0; ok = 1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #1;
            if (rts_pin != rts_hi) break;
            if (tx_start_ok) ok = 0;
            if (by_clk || bit_tick) units++;
        end
        chk(units == lag, {"R5 lag units ", tag}, units, lag);
        chk(ok, {"R5 no start during lag ", tag}, ok, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int lead, lag;
        bit by_clk, hi;
        void'($urandom(32'h1d5eed));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(rts_pin == 1'b0 && tx_start_ok == 1'b0, "reset idle state", {rts_pin, tx_start_ok}, 0);

        // R1, R7 manual levels under both polarities; R10 manual permit
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cfg_auto = 0; cfg_manual_rts = k[0]; cfg_rts_act_high = k[1];
            #1;
            chk(rts_pin == pin_level(k[0], k[1]), "R1/R7 manual rts level", rts_pin, pin_level(k[0], k[1]));
            chk(tx_start_ok == 1'b1, "R10 manual permit", tx_start_ok, 1);
        end
        // R1 ignores pending in manual mode
        @(negedge clk);
        cfg_manual_rts = 0; cfg_rts_act_high = 1; tx_pending = 1;
        repeat (3) @(negedge clk);
        #1;
        chk(rts_pin == 1'b0, "R1 pending ignored in manual", rts_pin, 0);
        tx_pending = 0;

        // R9 pad enables
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cfg_drv_tx_en = k[0]; cfg_drv_rts_en = k[1];
            #1;
            chk(tx_oe == k[0] && rts_oe == k[1], "R9 output enables", {tx_oe, rts_oe}, k);
        end

        // directed frames
        run_frame(5, 4, 1, 1, "clk");
        run_frame(3, 2, 0, 0, "tick");
        run_frame(0, 0, 1, 1, "R4 zero lead/lag");

        // R6 resume during lag
        @(negedge clk);
        cfg_auto = 1; cfg_count_clk = 1; cfg_lead = 8'd2; cfg_lag = 8'd10; cfg_rts_act_high = 1;
        tx_pending = 1;
        repeat (6) @(negedge clk);
        tx_pending = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(rts_pin == 1'b1 && tx_start_ok == 1'b0, "R5 in lag", {rts_pin, tx_start_ok}, 2);
        tx_pending = 1;
        @(negedge clk); #1;
        chk(tx_start_ok == 1'b1 && rts_pin == 1'b1, "R6 resume without lead", tx_start_ok, 1);
        tx_pending = 0;
        repeat (14) @(negedge clk);
        #1;
        chk(rts_pin == 1'b0, "R5 rts released after lag", rts_pin, 0);

        // R8 CTS gating in send
        @(negedge clk);
        cfg_lead = 8'd0; cfg_lag = 8'd0; tx_pending = 1;
        cfg_cts_gate = 1; cfg_cts_act_high = 0; cts_pin = 1;
        @(negedge clk); #1;
        chk(tx_start_ok == 1'b0, "R8 CTS inactive blocks start", tx_start_ok, 0);
        cts_pin = 0; #1;
        chk(tx_start_ok == 1'b1, "R8 CTS active allows start", tx_start_ok, 1);
        cfg_cts_gate = 0; cts_pin = 1; #1;
        chk(tx_start_ok == 1'b1, "R8 CTS ignored without gate", tx_start_ok, 1);
        tx_pending = 0;
        repeat (2) @(negedge clk);

        // random frames
        for (int n = 0; n < 24; n++) begin
            lead   = int'($urandom_range(0, 15));
            lag    = int'($urandom_range(0, 15));
            by_clk = 1'($urandom_range(0, 1));
            hi     = 1'($urandom_range(0, 1));
            tick_per = int'($urandom_range(1, 4));
            run_frame(lead, lag, by_clk, hi, "random R3");
        end

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule